// File: doc/BRIEF.md
# Ethernet Frame Encapsulator with FCS

This block takes a raw Ethernet frame one byte at a time on a valid/ready input. The frame runs from the destination address through the payload and carries no check sequence. The block emits the byte sequence that goes on the wire. First come seven preamble bytes and a start delimiter. Then the frame bytes pass straight through, followed by zero fill up to the minimum frame size. Last comes a four-byte CRC-32 check value. When the final check byte leaves, the block reports the total number of bytes it produced, with the preamble and delimiter included.

The output has no backpressure. Generated bytes (preamble, fill and check value) appear one per cycle, and the input is held off while they are produced. A frame byte appears on the output in the same cycle it is accepted.

Output length is capped at `MAX_OUT` bytes, 1530 by default. A frame that would exceed the cap is dropped at the first byte that crosses the limit. The block then flags the drop, reports a length of zero, and swallows the rest of the input frame without producing output. Any bytes already emitted for that frame are not taken back, so downstream logic discards the frame when it sees the drop flag.

Top module: `encap_top`

## Requirements
- R1: Each frame's output begins with seven bytes of 0x55 followed by one byte of 0xD5.
- R2: Every accepted input byte (inValid and inReady both high) appears unchanged on outData, with outValid high, in the same cycle. Frame bytes keep their input order.
- R3: If an input frame has fewer than MIN_FRAME (60) bytes, zero bytes follow it until MIN_FRAME frame bytes have been emitted.
- R4: After the frame and fill come four check bytes, least significant byte first. The check value is a reflected CRC-32 (polynomial 0xEDB88320, initial value 0xFFFFFFFF, final inversion, each byte taken LSB first) computed over the frame bytes and fill only.
- R5: frameDone pulses for exactly one cycle, together with the last check byte. frameLen then equals the padded frame length plus 12.
- R6: inReady is low in every cycle in which a preamble, delimiter, fill or check byte is emitted.
- R7: When the input frame reaches MAX_OUT-11 bytes (1519 by default), that byte is not emitted. frameDrop pulses for one cycle with frameLen equal to 0. The rest of the frame is accepted with no output, and no check bytes and no frameDone follow.
- R8: After reset, outValid, inReady, frameDone and frameDrop are all low.
- R9: A frame that follows a dropped frame is encapsulated normally.
- R10: A frame of exactly MIN_FRAME bytes gets no fill (length 72). A frame of exactly MAX_OUT-12 bytes is accepted with length MAX_OUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input frame byte |
| inLast | input | 1 | Marks the last byte of the input frame |
| inReady | output | 1 | Block accepts the input byte this cycle |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output wire byte |
| frameDone | output | 1 | One-cycle pulse on the last check byte |
| frameDrop | output | 1 | One-cycle pulse when an oversize frame is dropped |
| frameLen | output | 11 | Output length while frameDone is high; zero while frameDrop is high |

## Verification
The hardest case to reach is the oversize drop. It happens only after more than fifteen hundred bytes have been streamed, and it depends on exactly which byte crosses the limit. The stimulus sends a frame that just fits, one whose final byte is the first to cross the limit (so the drop lands with inLast high), and one that runs past the limit so that the drain path has to swallow a tail. A normal frame follows straight after the drops to show that the state recovers. Stall bubbles on the input show that fill and check generation are tied to the byte count and not to cycle timing.

// File: rtl/encap_pkg.sv
package encap_pkg;

  localparam logic [7:0]  PRE_BYTE = 8'h55;
  localparam logic [7:0]  SFD_BYTE = 8'hD5;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

  // which byte source drives the output this cycle
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRE,
    SEL_DATA,
    SEL_PAD,
    SEL_FCS
  } byteSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_PAD,
    ST_FCS,
    ST_DRAIN
  } encState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     clr;
    byteSel_e sel;
  } dpCtrl_t;

  // one byte of reflected CRC-32, least significant bit first
  function automatic logic [31:0] crcByte(input logic [31:0] crcIn, input logic [7:0] b);
    logic [31:0] c;
    c = crcIn;
    for (int k = 0; k < 8; k++) begin
      if (c[0] ^ b[k]) c = (c >> 1) ^ CRC_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/encap_datapath.sv
module encap_datapath
  import encap_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  dpCtrl_t          ctrl,
  input  logic [7:0]       inData,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic [CNT_W-1:0] frameCnt,
  output logic [2:0]       subCnt
);

  logic [31:0] crcReg;
  logic [31:0] fcsWord;
  logic [7:0]  curByte;

  assign fcsWord = ~crcReg;

  always_comb begin
    case (ctrl.sel)
      SEL_PRE:  curByte = (subCnt == 3'd7) ? SFD_BYTE : PRE_BYTE;
      SEL_DATA: curByte = inData;
      SEL_PAD:  curByte = 8'h00;
      SEL_FCS: begin
        case (subCnt[1:0])
          2'd0:    curByte = fcsWord[7:0];
          2'd1:    curByte = fcsWord[15:8];
          2'd2:    curByte = fcsWord[23:16];
          default: curByte = fcsWord[31:24];
        endcase
      end
      default:  curByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || ctrl.clr) begin
      crcReg   <= CRC_SEED;
      frameCnt <= '0;
      subCnt   <= '0;
    end else begin
      case (ctrl.sel)
        SEL_PRE, SEL_FCS: subCnt <= subCnt + 3'd1;
        SEL_DATA, SEL_PAD: begin
          crcReg   <= crcByte(crcReg, curByte);
          frameCnt <= frameCnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign outValid = (ctrl.sel != SEL_NONE);
  assign outData  = curByte;

endmodule

// File: rtl/encap_control.sv
module encap_control
  import encap_pkg::*;
#(
  parameter int CNT_W     = 11,
  parameter int MIN_FRAME = 60,
  parameter int MAX_FRAME = 1518
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inLast,
  input  logic [CNT_W-1:0] frameCnt,
  input  logic [2:0]       subCnt,
  output dpCtrl_t          ctrl,
  output logic             inReady,
  output logic             frameDone,
  output logic             frameDrop
);

  localparam logic [CNT_W-1:0] LIMIT_CNT = CNT_W'(MAX_FRAME);
  localparam logic [CNT_W-1:0] PAD_LAST  = CNT_W'(MIN_FRAME - 1);

  encState_e state, nextState;

  always_comb begin
    nextState = state;
    ctrl.clr  = 1'b0;
    ctrl.sel  = SEL_NONE;
    inReady   = 1'b0;
    frameDone = 1'b0;
    frameDrop = 1'b0;
    case (state)
      ST_IDLE: begin
        ctrl.clr = 1'b1;
        if (inValid) nextState = ST_PRE;
      end
      ST_PRE: begin
        ctrl.sel = SEL_PRE;
        if (subCnt == 3'd7) nextState = ST_DATA;
      end
      ST_DATA: begin
        inReady = 1'b1;
        if (inValid) begin
          if (frameCnt == LIMIT_CNT) begin
            frameDrop = 1'b1;
            nextState = inLast ? ST_IDLE : ST_DRAIN;
          end else begin
            ctrl.sel = SEL_DATA;
            if (inLast) nextState = (frameCnt < PAD_LAST) ? ST_PAD : ST_FCS;
          end
        end
      end
      ST_PAD: begin
        ctrl.sel = SEL_PAD;
        if (frameCnt == PAD_LAST) nextState = ST_FCS;
      end
      ST_FCS: begin
        ctrl.sel = SEL_FCS;
        if (subCnt == 3'd3) begin
          frameDone = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_DRAIN: begin
        inReady = 1'b1;
        if (inValid && inLast) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

endmodule

// File: rtl/encap_top.sv
module encap_top
  import encap_pkg::*;
#(
  parameter int MIN_FRAME = 60,
  parameter int MAX_OUT   = 1530
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [7:0]  inData,
  input  logic        inLast,
  output logic        inReady,
  output logic        outValid,
  output logic [7:0]  outData,
  output logic        frameDone,
  output logic        frameDrop,
  output logic [10:0] frameLen
);

  localparam int CNT_W     = $clog2(MAX_OUT + 1);
  localparam int OVERHEAD  = 12;
  localparam int MAX_FRAME = MAX_OUT - OVERHEAD;

  dpCtrl_t          ctrl;
  logic [CNT_W-1:0] frameCnt;
  logic [2:0]       subCnt;

  encap_control #(
    .CNT_W(CNT_W), .MIN_FRAME(MIN_FRAME), .MAX_FRAME(MAX_FRAME)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast),
    .frameCnt(frameCnt), .subCnt(subCnt), .ctrl(ctrl),
    .inReady(inReady), .frameDone(frameDone), .frameDrop(frameDrop)
  );

  encap_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .inData(inData),
    .outValid(outValid), .outData(outData),
    .frameCnt(frameCnt), .subCnt(subCnt)
  );

  assign frameLen = frameDone ? 11'(frameCnt + CNT_W'(OVERHEAD)) : 11'd0;

endmodule

// File: rtl/encap_checker.sv
module encap_checker #(
  parameter int MIN_FRAME = 60,
  parameter int MAX_OUT   = 1530
) (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic        inReady,
  input logic [7:0]  inData,
  input logic        outValid,
  input logic [7:0]  outData,
  input logic        frameDone,
  input logic        frameDrop,
  input logic [10:0] frameLen
);

  localparam logic [10:0] LEN_MIN = 11'(MIN_FRAME + 12);
  localparam logic [10:0] LEN_MAX = 11'(MAX_OUT);

  AST_DATA_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && outValid) |-> (outData == inData)); // R2
  AST_READY_LOW_GEN: assert property (@(posedge clk) disable iff (rst)
    (outValid && !(inValid && inReady)) |-> !inReady); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frameDone |=> !frameDone); // R5
  AST_DONE_WITH_BYTE: assert property (@(posedge clk) disable iff (rst)
    frameDone |-> (outValid && !inReady)); // R5
  AST_DONE_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    frameDone |-> (frameLen >= LEN_MIN && frameLen <= LEN_MAX)); // R5
  AST_DROP_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    frameDrop |-> (frameLen == 11'd0 && !frameDone)); // R7
  AST_DROP_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    frameDrop |-> !outValid); // R7
  AST_DROP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frameDrop |=> !frameDrop); // R7

endmodule

bind encap_top encap_checker #(.MIN_FRAME(MIN_FRAME), .MAX_OUT(MAX_OUT)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
  .outValid(outValid), .outData(outData), .frameDone(frameDone),
  .frameDrop(frameDrop), .frameLen(frameLen)
);

// File: tb/tb_encap_top.sv
module tb_encap_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid, inLast, inReady;
  logic [7:0]  inData;
  logic        outValid, frameDone, frameDrop;
  logic [7:0]  outData;
  logic [10:0] frameLen;

  always #4 clk = ~clk;

  encap_top dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inReady(inReady), .outValid(outValid), .outData(outData),
    .frameDone(frameDone), .frameDrop(frameDrop), .frameLen(frameLen)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [7:0] expByte[$];
  string      expTag[$];
  int         expEvt[$];
  string      evtTag[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed + i * 7) ^ (i >> 3));
  endfunction

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++) r = (r[0] ^ b[k]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic pushByte(input logic [7:0] b, input string t);
    expByte.push_back(b);
    expTag.push_back(t);
  endtask

  task automatic sendFrame(input int len, input int seed, input int gapEvery,
                           input string lenTag);
    logic [31:0] crc;
    logic [31:0] fcs;
    bit acc;
    crc = 32'hFFFFFFFF;
    for (int i = 0; i < 7; i++) pushByte(8'h55, "R1");
    pushByte(8'hD5, "R1");
    if (len > 1518) begin
      for (int i = 0; i < 1518; i++) pushByte(pat(seed, i), "R2");
      expEvt.push_back(0);
      evtTag.push_back(lenTag);
    end else begin
      for (int i = 0; i < len; i++) begin
        pushByte(pat(seed, i), "R2");
        crc = crcStep(crc, pat(seed, i));
      end
      for (int i = len; i < 60; i++) begin
        pushByte(8'h00, "R3");
        crc = crcStep(crc, 8'h00);
      end
      fcs = ~crc;
      for (int i = 0; i < 4; i++) pushByte(fcs[8*i +: 8], "R4");
      expEvt.push_back((len < 60 ? 60 : len) + 12);
      evtTag.push_back(lenTag);
    end
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1;
      inData  = pat(seed, i);
      inLast  = (i == len - 1);
      do begin
        @(negedge clk);
        acc = inReady;
        @(posedge clk);
        #1;
      end while (!acc);
      if (gapEvery != 0 && (i % gapEvery) == gapEvery - 1) begin
        inValid = 1'b0;
        inLast  = 1'b0;
        @(posedge clk);
        #1;
      end
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    while (expByte.size() != 0 || expEvt.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  // scoreboard monitor
  initial begin
    logic [7:0] b;
    string t;
    int e;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (outValid) begin
          if (expByte.size() == 0) begin
            check(1'b0, "R2", "unexpected output byte", int'(outData), -1);
          end else begin
            b = expByte.pop_front();
            t = expTag.pop_front();
            check(outData == b, t, "output byte", int'(outData), int'(b));
            if (t != "R2") check(!inReady, "R6", "inReady during generated byte", int'(inReady), 0);
          end
        end
        if (frameDone) begin
          if (expEvt.size() == 0) begin
            check(1'b0, "R5", "unexpected frameDone", int'(frameLen), -1);
          end else begin
            e = expEvt.pop_front();
            t = evtTag.pop_front();
            check(e != 0, "R7", "frameDone on oversize frame", int'(frameLen), 0);
            check(int'(frameLen) == e, t, "frameLen at done", int'(frameLen), e);
          end
        end
        if (frameDrop) begin
          if (expEvt.size() == 0) begin
            check(1'b0, "R7", "unexpected frameDrop", 1, 0);
          end else begin
            e = expEvt.pop_front();
            t = evtTag.pop_front();
            check(e == 0, "R7", "frameDrop on legal frame", 0, e);
            check(frameLen == 11'd0, "R7", "frameLen at drop", int'(frameLen), 0);
            check(!outValid, "R7", "outValid at drop", int'(outValid), 0);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R5 watchdog: actual 0 expected 1 completed run");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    inValid = 1'b0;
    inLast  = 1'b0;
    inData  = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    // R8: idle outputs after reset
    check(!outValid,  "R8", "outValid after reset",  int'(outValid), 0);
    check(!inReady,   "R8", "inReady after reset",   int'(inReady), 0);
    check(!frameDone, "R8", "frameDone after reset", int'(frameDone), 0);
    check(!frameDrop, "R8", "frameDrop after reset", int'(frameDrop), 0);
    @(posedge clk);
    #1;

    sendFrame(1,    3,  0, "R5");   // R3 heavy fill
    sendFrame(20,   11, 3, "R5");   // fill with stalls
    sendFrame(59,   29, 0, "R5");   // one fill byte
    sendFrame(60,   41, 0, "R10");  // no fill
    sendFrame(61,   53, 4, "R5");
    sendFrame(100,  67, 5, "R5");
    sendFrame(1518, 79, 0, "R10");  // largest legal frame
    sendFrame(1519, 83, 0, "R7");   // drop on the final byte
    sendFrame(64,   97, 0, "R9");   // recovery after drop
    sendFrame(1530, 5,  7, "R7");   // drop with a tail to drain
    sendFrame(75,   17, 2, "R9");

    check(expByte.size() == 0, "R2", "leftover expected bytes", expByte.size(), 0);
    check(expEvt.size() == 0,  "R5", "leftover expected events", expEvt.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule